// File: doc/BRIEF.md
# Event-Triggered One-Shot Pulse Timer

This block turns a trigger pin into a single clean output pulse of programmable length. The pin level can be inverted, passes through a two-stage synchronizer and an optional noise filter, and an edge detector then turns a qualifying edge into a one-cycle trigger. The trigger starts a counter from zero with the output high. The output drops when the counter equals the programmed compare value, so the pulse lasts compare+1 clock cycles.

In synchronous start mode the whole pulse is aligned to the clock. In asynchronous start mode the output rises as soon as a qualifying pin change appears. The pulse still ends on the same clock edge as it would in synchronous mode. The end of every pulse sets a sticky interrupt flag, and an enable bit gates that flag onto the interrupt line.

Software reaches the configuration, the compare value, the counter and the flag through a small word-wide register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `evt_pulse_timer`

## Requirements
- R1: After reset every register reads 0 and `wave_out`, `wave_oe` and `irq` are low.
- R2: Address 0 is the configuration word: bit0 run enable, bit1 asynchronous start, bit2 any-edge, bit3 filter enable, bit4 pin invert, bit5 pin drive enable. The pin level XOR the invert bit forms the event level. With any-edge 0 only a 0-to-1 change of the event level triggers. With any-edge 1 both directions trigger.
- R3: In synchronous mode with the filter off, a pin change made between clock edges shows `wave_out` high after the 4th following rising edge. The output stays high for exactly compare+1 cycles, where the compare value is at address 1.
- R4: In asynchronous mode, `wave_out` goes high combinationally on a qualifying pin change, before any clock edge. It falls on the same edge as in synchronous mode.
- R5: With the filter on, a new event level is accepted only after 4 consecutive equal samples. This adds 4 cycles to the rise of R3. A level held for 3 cycles produces no pulse.
- R6: A trigger that arrives while a pulse is running is ignored. The pulse width is unchanged and no second pulse follows.
- R7: The counter at address 2 is readable and writable. It restarts at 0 on a trigger and holds the compare value after the pulse ends.
- R8: Address 3 holds bit0 = done flag and bit1 = interrupt enable. The flag sets when a pulse ends. Writing 1 to bit0 clears the flag; writing 0 leaves it unchanged. `irq` is the flag AND the enable.
- R9: With pin drive enable 0, `wave_oe` and `wave_out` stay low, while pulses still run and still set the flag.
- R10: With run enable 0, the counter holds its value, any running pulse stops and `wave_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Trigger pin, asynchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| wave_out | output | 1 | Pulse output value |
| wave_oe | output | 1 | Pulse output drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter, two synchronizer stages and a filter length of 4. It sweeps compare values 0 to 3 across all 16 combinations of start mode, edge mode, filter and invert, in both pin directions. Each case is compared cycle by cycle with a waveform computed from the latencies in R3 to R5. The small compare values keep every combination reachable in a short run. Separate directed cases cover a filtered 3-cycle glitch, retriggering during a long pulse, disabling mid-pulse, the pin drive enable, the counter write and the write-one-to-clear flag.

// File: rtl/evt_pulse_pkg.sv
package evt_pulse_pkg;

  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_CMP = 2'd1;
  localparam logic [1:0] A_CNT = 2'd2;
  localparam logic [1:0] A_IRQ = 2'd3;
  localparam int CFG_W = 6;

  // bit5 down to bit0
  typedef struct packed {
    logic oe;
    logic inv;
    logic filt;
    logic any_edge;
    logic async_start;
    logic en;
  } cfg_t;

  // An edge of the event level qualifies when it is a change and either
  // both directions are allowed or the new level is high.
  function automatic logic edge_qualifies(input logic prev, input logic cur,
                                          input logic any_edge);
    return (prev ^ cur) & (any_edge | cur);
  endfunction

endpackage

// File: rtl/evt_pulse_sync.sv
module evt_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/evt_pulse_filter.sv
module evt_pulse_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  output logic lvl
);
  localparam int CW = $clog2(LEN) + 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (s == lvl_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      run_q <= '0;
      lvl_q <= s;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign lvl = lvl_q;

  AST_FILTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> ($past(run_q) == LAST && $past(s) == lvl_q)); // R5
endmodule

// File: rtl/evt_pulse_edge.sv
module evt_pulse_edge
  import evt_pulse_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  input  logic any_edge,
  output logic ref_lvl,
  output logic trig
);
  logic prev_q, trig_q, edge_hit;

  assign edge_hit = edge_qualifies(prev_q, lvl, any_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      trig_q <= en & edge_hit;
    end
  end

  assign ref_lvl = prev_q;
  assign trig    = trig_q;

  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && !any_edge) |=> ref_lvl); // R2
endmodule

// File: rtl/evt_pulse_counter.sv
module evt_pulse_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trig,
  input  logic [CNT_W-1:0] cmp,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             pulse_end
);
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign pulse_end = run_q & en & (cnt_q == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en) begin
      run_q <= 1'b0;
      if (cnt_we) cnt_q <= cnt_wdata;
    end else if (run_q) begin
      if (pulse_end)   run_q <= 1'b0;
      else if (cnt_we) cnt_q <= cnt_wdata;
      else             cnt_q <= count_step(cnt_q);
    end else if (trig) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_wdata;
    end
  end

  assign running = run_q;
  assign count   = cnt_q;

  AST_END_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end |=> !run_q); // R3
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt_q == '0)); // R7
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en && !pulse_end) |=> run_q); // R6
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_we) |=> (!run_q && $stable(cnt_q))); // R10
endmodule

// File: rtl/evt_pulse_timer.sv
module evt_pulse_timer
  import evt_pulse_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             wave_out,
  output logic             wave_oe,
  output logic             irq
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] cmp_q;
  logic             ie_q, flag_q;

  logic raw_lv, sync_lv, filt_lv, evt_lv;
  logic ref_lvl, trig, running, pulse_end, pend_raw, wave_int;
  logic [CNT_W-1:0] count;
  logic cnt_we, flag_clr;

  assign raw_lv = pin_in ^ cfg_q.inv;

  evt_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lv), .q(sync_lv));

  evt_pulse_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .s(sync_lv), .lvl(filt_lv));

  assign evt_lv = cfg_q.filt ? filt_lv : sync_lv;

  evt_pulse_edge u_edge (
    .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .lvl(evt_lv),
    .any_edge(cfg_q.any_edge), .ref_lvl(ref_lvl), .trig(trig));

  assign cnt_we = reg_we && (reg_addr == A_CNT);

  evt_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .trig(trig), .cmp(cmp_q),
    .cnt_we(cnt_we), .cnt_wdata(reg_wdata), .running(running),
    .count(count), .pulse_end(pulse_end));

  // Event in flight: raw level already qualifies against the last accepted level.
  assign pend_raw = edge_qualifies(ref_lvl, raw_lv, cfg_q.any_edge);
  assign wave_int = cfg_q.en & (running | (cfg_q.async_start & (pend_raw | trig)));
  assign wave_out = wave_int & cfg_q.oe;
  assign wave_oe  = cfg_q.oe;

  assign flag_clr = reg_we && (reg_addr == A_IRQ) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cmp_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CFG) cfg_q <= cfg_t'(reg_wdata[CFG_W-1:0]);
      if (reg_we && reg_addr == A_CMP) cmp_q <= reg_wdata;
      if (reg_we && reg_addr == A_IRQ) ie_q  <= reg_wdata[1];
      flag_q <= pulse_end | (flag_q & ~flag_clr);
    end
  end

  assign irq = flag_q & ie_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:   reg_rdata[CFG_W-1:0] = cfg_q;
      A_CMP:   reg_rdata = cmp_q;
      A_CNT:   reg_rdata = count;
      default: reg_rdata[1:0] = {ie_q, flag_q};
    endcase
  end

  AST_FLAG_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end |=> flag_q); // R8
  AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R8
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |-> !wave_out); // R10
endmodule

// File: tb/evt_pulse_timer_test.sv
module evt_pulse_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        wave_out, wave_oe, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  evt_pulse_timer uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wave_out(wave_out), .wave_oe(wave_oe), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive pin at a negedge, then sample index 0 at +1 and indices 1..n after later negedges.
  task automatic capture(input logic lvl, input int n, output logic [63:0] w);
    w = '0;
    @(negedge clk);
    pin_in = lvl;
    #1;
    w[0] = wave_out;
    for (int m = 1; m <= n; m++) begin
      @(negedge clk);
      #1;
      w[m] = wave_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, d2;
    logic [63:0] w, e;
    int highs, first;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(2'd0, d); chk("R1 cfg", d, 0);
    rd(2'd1, d); chk("R1 cmp", d, 0);
    rd(2'd2, d); chk("R1 cnt", d, 0);
    rd(2'd3, d); chk("R1 irq reg", d, 0);
    chk("R1 outputs", {wave_out, wave_oe, irq}, 0);

    // Sweep: cmp x async x any_edge x filter x invert x direction (R2 R3 R4 R5)
    for (int c = 0; c < 4; c++)
      for (int mode = 0; mode < 16; mode++)
        for (int dir = 0; dir < 2; dir++) begin
          logic as, an, fl, iv, nl, acc;
          int dly, n;
          as = mode[0]; an = mode[1]; fl = mode[2]; iv = mode[3];
          nl = dir[0];
          wr(2'd0, {10'd0, 1'b1, iv, fl, an, as, 1'b0});
          pin_in = ~nl;
          idle(14);
          wr(2'd3, 16'h0001);
          wr(2'd1, 16'(c));
          wr(2'd0, {10'd0, 1'b1, iv, fl, an, as, 1'b1});
          acc = an || ((nl ^ iv) == 1'b1);
          dly = fl ? 8 : 4;
          n = dly + c + 5;
          e = '0;
          for (int m = 0; m <= n; m++)
            e[m] = acc && (as ? (m <= dly + c) : (m >= dly && m <= dly + c));
          capture(nl, n, w);
          if (as) chk("R4 async waveform", w[31:0], e[31:0]);
          else if (fl) chk("R5 filtered waveform", w[31:0], e[31:0]);
          else chk("R3 sync waveform", w[31:0], e[31:0]);
          rd(2'd3, d);
          chk("R2 flag after edge", {31'd0, d[0]}, {31'd0, acc});
          if (acc) begin
            rd(2'd2, d);
            chk("R7 count holds compare", d, c);
          end
        end

    // R5 a 3-cycle glitch is rejected by the filter
    wr(2'd0, 16'h0028);
    pin_in = 1'b0;
    idle(14);
    wr(2'd3, 16'h0001);
    wr(2'd1, 16'd1);
    wr(2'd0, 16'h0029);
    @(negedge clk); pin_in = 1'b1;
    idle(3);        pin_in = 1'b0;
    highs = 0;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk); #1;
      if (wave_out) highs++;
    end
    chk("R5 glitch no pulse", highs, 0);
    rd(2'd3, d);
    chk("R5 glitch no flag", d[0], 0);

    // R6 retrigger ignored (any edge, sync, cmp 12)
    wr(2'd0, 16'h0024);
    pin_in = 1'b0;
    idle(10);
    wr(2'd1, 16'd12);
    wr(2'd0, 16'h0025);
    highs = 0; first = -1;
    for (int m = 0; m < 40; m++) begin
      @(negedge clk);
      if (m == 0) pin_in = 1'b1;
      if (m == 6) pin_in = 1'b0;
      if (m == 9) pin_in = 1'b1;
      #1;
      if (wave_out) begin
        highs++;
        if (first < 0) first = m;
      end
    end
    chk("R6 single pulse width", highs, 13);
    chk("R6 pulse start", first, 4);

    // R8 flag, enable and write-one-to-clear
    rd(2'd3, d);
    chk("R8 flag set, ie off", d[1:0], 2'b01);
    chk("R8 irq gated off", irq, 0);
    wr(2'd3, 16'h0002);
    rd(2'd3, d);
    chk("R8 write 0 keeps flag", d[1:0], 2'b11);
    chk("R8 irq raised", irq, 1);
    wr(2'd3, 16'h0003);
    rd(2'd3, d);
    chk("R8 write 1 clears flag", d[1:0], 2'b10);
    chk("R8 irq cleared", irq, 0);

    // R9 drive enable off: no output, pulse still completes
    wr(2'd0, 16'h0000);
    pin_in = 1'b0;
    idle(10);
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0001);
    highs = 0;
    for (int m = 0; m < 14; m++) begin
      @(negedge clk);
      if (m == 0) pin_in = 1'b1;
      #1;
      if (wave_out || wave_oe) highs++;
    end
    chk("R9 pin released", highs, 0);
    rd(2'd3, d);
    chk("R9 flag still set", d[0], 1);
    chk("R9 irq follows", irq, 1);
    wr(2'd3, 16'h0001);

    // R7 counter write and read back while idle
    wr(2'd2, 16'h1234);
    rd(2'd2, d);
    chk("R7 count write", d, 16'h1234);

    // R10 disable mid-pulse: output low, count holds
    wr(2'd0, 16'h0020);
    pin_in = 1'b0;
    idle(10);
    wr(2'd1, 16'd40);
    wr(2'd0, 16'h0021);
    @(negedge clk); pin_in = 1'b1;
    idle(10);
    chk("R10 pulse running before disable", wave_out, 1);
    wr(2'd0, 16'h0020);
    #1;
    chk("R10 output low when disabled", wave_out, 0);
    rd(2'd2, d);
    idle(5);
    rd(2'd2, d2);
    chk("R10 count holds", d2, d);
    chk("R10 count below compare", (d > 0 && d < 40), 1);
    rd(2'd3, d);
    chk("R10 no end flag", d[0], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule